// File: doc/BRIEF.md
# Byte-Wide Boot Image Loader

After reset, while the boot mode is selected, this sequencer fills a 512-word, 24-bit program RAM from an external byte-wide memory. It first reads one configuration word at the image base address C000 and looks at its top bit. If that bit is set, it walks the 1536 image bytes upward from C000. Each group of three bytes, taken low byte first, then mid, then high, becomes one program word. Each finished word goes to the RAM address that matches its group number. If the bit is clear, loading is left to the host port. The loader raises a host-select flag and waits for that path to report completion.

Either way, the loader ends the same way. It issues a write of operating mode 2, which unmaps the boot ROM and re-enables program RAM access. It leaves one free cycle for a single-cycle operation, then pulses a jump to address zero and parks with `done` high. Interrupts are masked from the moment loading begins until the jump has been issued.

External reads are strobed with a fixed number of wait cycles. The address is held on the bus for `WAIT_CYC+1` cycles, and data is taken only in the last of them.

Top module: `boot_image_loader`

## Requirements
- R1: When `boot_en` is high in idle, the loader reads the word at address C000. Bit 23 of that word set to 1 selects the byte-memory load. Set to 0, it selects the host path.
- R2: On the byte path, read addresses run from C000 up to C5FF, rising by one per byte, and never leave that window.
- R3: RAM word k is formed as {byte 3k+2, byte 3k+1, byte 3k}. Byte n is the byte at address C000+n, so the high byte sits in bits 23:16 and the low byte in bits 7:0.
- R4: Exactly 512 RAM writes occur, at addresses 0 to 511 in ascending order. Each write is issued only after the high byte of its word has been captured.
- R5: When loading ends, `mode_wr` pulses for one cycle with `mode_val` equal to 2'b10. In every other cycle `mode_val` is 0.
- R6: `jump_go` pulses exactly two cycles after `mode_wr`, with one empty cycle between them. `done` rises the cycle after `jump_go` and stays high until reset.
- R7: `irq_mask` is high in every cycle from leaving idle through the jump cycle. This includes every RAM write cycle. It is low in idle and once `done` is high.
- R8: On the host path, `host_sel` stays high with no external read and no RAM write. This continues until `host_done` is sampled high. The R5/R6 end sequence then starts on the next cycle.
- R9: Every external read holds `ext_rd` and `ext_addr` for `WAIT_CYC+1` cycles. Data is taken only in the final one of those cycles.
- R10: During reset and while idle, all outputs are low. The loader stays idle as long as `boot_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Boot mode active; starts the loader from idle |
| ext_rd | output | 1 | External read strobe |
| ext_addr | output | ADDR_W | External byte address |
| ext_data | input | 24 | External read data (probe uses bit 23, bytes use bits 7:0) |
| pram_we | output | 1 | Program RAM write enable |
| pram_addr | output | log2(N_WORDS) | Program RAM word address |
| pram_wdata | output | 24 | Packed program word |
| host_sel | output | 1 | Host load path selected, waiting |
| host_done | input | 1 | Host load path finished |
| irq_mask | output | 1 | Interrupts held disabled |
| mode_wr | output | 1 | One-cycle operating mode write |
| mode_val | output | 2 | Mode value written (2'b10) |
| jump_go | output | 1 | One-cycle jump to address zero |
| done | output | 1 | Loader finished |

## Verification
Each read strobe spans `WAIT_CYC+1` cycles. The bench's memory model returns junk in every strobe cycle except the last, so a sample taken too early shows up as a corrupted word or a misrouted probe. A word's write appears one cycle after its high byte's final read cycle. The mode write shares the cycle of the last RAM write. The jump follows two cycles later, and `done` one cycle after that. On the host path, the mode write comes one cycle after `host_done` is sampled.

All outputs are observed at the falling edge, halfway between the edges that update them. Cycle distances are measured by a free-running counter at that same point, not by waiting a fixed number of cycles.

// File: rtl/boot_image_loader.sv
module boot_image_loader #(
  parameter int ADDR_W = 16,
  parameter int N_WORDS = 512,
  parameter int WAIT_CYC = 2,
  parameter logic [ADDR_W-1:0] IMG_BASE = 16'hC000,
  localparam int PA_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  output logic              ext_rd,
  output logic [ADDR_W-1:0] ext_addr,
  input  logic [23:0]       ext_data,
  output logic              pram_we,
  output logic [PA_W-1:0]   pram_addr,
  output logic [23:0]       pram_wdata,
  output logic              host_sel,
  input  logic              host_done,
  output logic              irq_mask,
  output logic              mode_wr,
  output logic [1:0]        mode_val,
  output logic              jump_go,
  output logic              done
);
  localparam int NB   = 3 * N_WORDS;
  localparam int BI_W = $clog2(NB + 1);
  localparam int WC_W = $clog2(WAIT_CYC + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_LOAD, S_HOST, S_MODE, S_SLOT, S_JUMP, S_DONE
  } st_t;

  st_t             state;
  logic [WC_W-1:0] wcnt;
  logic [BI_W-1:0] byte_idx;
  logic [PA_W-1:0] word_idx;
  logic [1:0]      phase;
  logic [7:0]      lo_b, mid_b;
  logic            sample;
  wire             unused_bits = ^ext_data[22:8];

  assign ext_rd   = (state == S_PROBE) || (state == S_LOAD);
  assign ext_addr = IMG_BASE + ADDR_W'(byte_idx);
  assign sample   = ext_rd && (wcnt == WC_W'(WAIT_CYC));
  assign host_sel = (state == S_HOST);
  assign mode_wr  = (state == S_MODE);
  assign mode_val = mode_wr ? 2'b10 : 2'b00;
  assign jump_go  = (state == S_JUMP);
  assign done     = (state == S_DONE);
  assign irq_mask = (state != S_IDLE) && (state != S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wcnt       <= '0;
      byte_idx   <= '0;
      word_idx   <= '0;
      phase      <= '0;
      lo_b       <= '0;
      mid_b      <= '0;
      pram_we    <= 1'b0;
      pram_addr  <= '0;
      pram_wdata <= '0;
    end else begin
      pram_we <= 1'b0;
      if (ext_rd) wcnt <= sample ? '0 : wcnt + 1'b1;
      case (state)
        S_IDLE:  if (boot_en) state <= S_PROBE;
        S_PROBE: if (sample) state <= ext_data[23] ? S_LOAD : S_HOST;
        S_LOAD: if (sample) begin
          byte_idx <= byte_idx + 1'b1;
          phase    <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
          case (phase)
            2'd0:    lo_b  <= ext_data[7:0];
            2'd1:    mid_b <= ext_data[7:0];
            default: begin
              pram_we    <= 1'b1;
              pram_addr  <= word_idx;
              pram_wdata <= {ext_data[7:0], mid_b, lo_b};
              word_idx   <= word_idx + 1'b1;
              if (word_idx == PA_W'(N_WORDS - 1)) state <= S_MODE;
            end
          endcase
        end
        S_HOST:  if (host_done) state <= S_MODE;
        S_MODE:  state <= S_SLOT;
        S_SLOT:  state <= S_JUMP;
        S_JUMP:  state <= S_DONE;
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/loader_checks.sv
module loader_checks #(
  parameter int ADDR_W = 16,
  parameter int N_WORDS = 512,
  parameter logic [ADDR_W-1:0] IMG_BASE = 16'hC000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_rd,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              pram_we,
  input logic              host_sel,
  input logic              irq_mask,
  input logic              mode_wr,
  input logic [1:0]        mode_val,
  input logic              jump_go,
  input logic              done
);
  localparam logic [ADDR_W-1:0] LAST = IMG_BASE + ADDR_W'(3 * N_WORDS - 1);

  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |-> (ext_addr >= IMG_BASE && ext_addr <= LAST));
  assert_mode_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> mode_val == 2'b10);
  assert_mode_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |-> mode_val == 2'b00);
  assert_free_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !jump_go && !mode_wr);
  assert_jump_after_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_go |-> $past(mode_wr, 2));
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_write_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pram_we || ext_rd || jump_go) |-> irq_mask);
  assert_host_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |-> !ext_rd && !pram_we);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !ext_rd && !pram_we && !mode_wr && !host_sel);
endmodule

bind boot_image_loader loader_checks #(
  .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .IMG_BASE(IMG_BASE)
) u_checks (
  .clk(clk), .rst_n(rst_n), .ext_rd(ext_rd), .ext_addr(ext_addr),
  .pram_we(pram_we), .host_sel(host_sel), .irq_mask(irq_mask),
  .mode_wr(mode_wr), .mode_val(mode_val), .jump_go(jump_go), .done(done)
);

// File: tb/test_boot_image_loader.sv
module test_boot_image_loader;
  localparam int N = 512;
  localparam int W = 2;
  localparam logic [15:0] BASE = 16'hC000;
  localparam int PICK [8] = '{0, 1, 2, 85, 255, 256, 510, 511};

  logic clk = 0, rst_n = 0, boot_en = 0, host_done = 0, probe_hi = 1;
  logic ext_rd, pram_we, host_sel, irq_mask, mode_wr, jump_go, done;
  logic [15:0] ext_addr;
  logic [23:0] ext_data, pram_wdata;
  logic [8:0]  pram_addr;
  logic [1:0]  mode_val;

  always #4 clk = ~clk;

  boot_image_loader #(.N_WORDS(N), .WAIT_CYC(W)) i_boot_image_loader (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .ext_rd(ext_rd),
    .ext_addr(ext_addr), .ext_data(ext_data), .pram_we(pram_we),
    .pram_addr(pram_addr), .pram_wdata(pram_wdata), .host_sel(host_sel),
    .host_done(host_done), .irq_mask(irq_mask), .mode_wr(mode_wr),
    .mode_val(mode_val), .jump_go(jump_go), .done(done));

  int checks = 0, errors = 0;
  int age = 0, cyc = 0, rd_cyc = 0, wr_cnt = 0, wr_order_bad = 0, irq_bad = 0;
  int host_bad = 0, seq_bad = 0, mode_cyc = -1, jump_cyc = -1, host_seen = 0;
  int mode_v = 0;
  logic prev_rd = 0;
  logic [15:0] prev_addr = '0, amin = 16'hFFFF, amax = '0;
  logic [23:0] got [N];

  function automatic logic [7:0] img_byte(int i);
    return i[7:0] ^ {i[10:8], 5'b10110};
  endfunction

  function automatic logic [23:0] exp_word(int k);
    return {img_byte(3*k+2), img_byte(3*k+1), img_byte(3*k)};
  endfunction

  assign ext_data = (ext_rd && (age % (W+1)) == W)
      ? {(ext_addr == BASE) & probe_hi, 15'h0, img_byte(int'(ext_addr - BASE))}
      : 24'h5A5AA5;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    rd_cyc = 0; wr_cnt = 0; wr_order_bad = 0; irq_bad = 0; host_bad = 0;
    seq_bad = 0; mode_cyc = -1; jump_cyc = -1; host_seen = 0; mode_v = 0;
    amin = 16'hFFFF; amax = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (ext_rd && prev_rd && ext_addr == prev_addr) age = age + 1;
    else age = 0;
    if (ext_rd) begin
      rd_cyc++;
      if (ext_addr < amin) amin = ext_addr;
      if (ext_addr > amax) amax = ext_addr;
      if (prev_rd && ext_addr != prev_addr && ext_addr != prev_addr + 16'd1) seq_bad++;
    end
    prev_rd = ext_rd;
    prev_addr = ext_addr;
    if (pram_we) begin
      got[pram_addr] = pram_wdata;
      if (int'(pram_addr) != wr_cnt) wr_order_bad++;
      if (!irq_mask) irq_bad++;
      wr_cnt++;
    end
    if (mode_wr) begin mode_cyc = cyc; mode_v = int'(mode_val); end
    if (jump_go) jump_cyc = cyc;
    if (host_sel) host_seen++;
    if (host_sel && (ext_rd || pram_we)) host_bad++;
  end

  task automatic do_reset();
    rst_n = 0; boot_en = 0;
    repeat (3) @(negedge clk);
    clear_stats();
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mism;
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk({ext_rd, pram_we, host_sel, irq_mask, mode_wr, mode_val, jump_go, done} == '0,
        "R10", "outputs in reset", 0, 0);
    do_reset();
    repeat (5) @(negedge clk);
    chk(!irq_mask && !ext_rd && !done, "R10", "idle without boot_en", int'(irq_mask), 0);

    probe_hi = 1; boot_en = 1;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    chk(done, "R6", "byte load finished", int'(done), 1);
    chk(wr_cnt == N, "R4", "write count", wr_cnt, N);
    chk(wr_order_bad == 0, "R4", "write address order", wr_order_bad, 0);
    for (int k = 0; k < 8; k++)
      chk(got[PICK[k]] == exp_word(PICK[k]), "R3", "picked word",
          int'(got[PICK[k]]), int'(exp_word(PICK[k])));
    mism = 0;
    for (int k = 0; k < N; k++) if (got[k] != exp_word(k)) mism++;
    chk(mism == 0, "R3", "all words packed low-mid-high", mism, 0);
    chk(rd_cyc == (1 + 3*N) * (W+1), "R9", "read strobe cycles", rd_cyc, (1 + 3*N) * (W+1));
    chk(amin == BASE && amax == BASE + 16'(3*N-1), "R2", "address window",
        int'(amax), int'(BASE + 16'(3*N-1)));
    chk(seq_bad == 0, "R2", "ascending addresses", seq_bad, 0);
    chk(host_seen == 0, "R1", "bit23=1 picks byte path", host_seen, 0);
    chk(mode_v == 2, "R5", "mode value", mode_v, 2);
    chk(jump_cyc - mode_cyc == 2, "R6", "jump after free slot", jump_cyc - mode_cyc, 2);
    chk(irq_bad == 0, "R7", "writes masked", irq_bad, 0);
    repeat (4) @(negedge clk);
    chk(done && !irq_mask, "R7", "mask released at done", int'(irq_mask), 0);

    do_reset();
    probe_hi = 0; boot_en = 1;
    for (int t = 0; t < 100 && !host_sel; t++) @(negedge clk);
    chk(host_sel, "R1", "bit23=0 picks host path", int'(host_sel), 1);
    chk(rd_cyc == W+1, "R9", "probe strobe length", rd_cyc, W+1);
    repeat (50) @(negedge clk);
    chk(host_sel && !done && wr_cnt == 0, "R8", "waits for host_done", wr_cnt, 0);
    chk(host_bad == 0 && rd_cyc == W+1, "R8", "host path quiet", host_bad, 0);
    chk(irq_mask, "R7", "mask held while host loads", int'(irq_mask), 1);
    host_done = 1;
    @(negedge clk);
    host_done = 0;
    chk(mode_wr && mode_val == 2'b10, "R8", "mode write after host_done", int'(mode_val), 2);
    for (int t = 0; t < 10 && !done; t++) @(negedge clk);
    chk(jump_cyc - mode_cyc == 2 && done, "R6", "host path end sequence", jump_cyc - mode_cyc, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule